// File: doc/BRIEF.md
# UART Auto-Baud Rate Detector

This block measures the bit period of an incoming serial character and derives from it the divisor for a UART receiver's baud-rate generator. Software arms a measurement through a control register. The block then watches the receive line for the next character, which must be the calibration pattern 0x55. It times that character with a prescaled counter that runs on the system clock. When the measurement ends, it stores the result in the divisor register, clears its own arm bit and pulses a completion output.

The counter and divisor can be 8 or 16 bits wide. In 8-bit mode the count wraps at 256 and only the low divisor byte is written. If the count wraps during a measurement, a sticky overflow flag is set, and only a software write clears it. While a measurement is pending or running, the block tells the receiver to discard the character it is receiving. In synchronous mode the feature stays idle.

The line is sampled through a two-stage synchronizer. Timing runs from the falling edge of the start bit to the fifth falling edge of the character, counting the start edge. For 0x55 that span is exactly eight bit times. The prescaler divides by 8 × oversampling, so the count is the divisor for the chosen oversampling rate.

Top module: `uart_autobaud`

## Requirements
- R1: Writing the control register (address 0) with bit 0 = 1 and bit 3 = 0 arms the detector. The arm bit reads back at address 0, bit 0. Only the first character that starts after arming is measured. A later character leaves the divisor unchanged.
- R2: With T the bit period in clock cycles and P the prescale (P = 128 when control bit 2 = 1, the 16x rate; P = 512 when bit 2 = 0, the 64x rate), the loaded divisor is floor((8T−1)/P), taken modulo the selected width. This is within one count of 8T/P. Timing begins at the start-bit falling edge and ends at the fifth falling edge.
- R3: When a measurement completes, the hardware clears the arm bit, and `measDone` is high for exactly one cycle. That cycle is the first one in which the new divisor is visible.
- R4: Control bit 4 reads as the overflow flag. It is set when the counter wraps from all ones within the selected width. It stays set until a control write with bit 4 = 0. A write with bit 4 = 1 leaves it set. If a wrap and a clearing write fall in the same cycle, the flag ends up set.
- R5: Control bit 1 = 1 selects 16-bit mode, in which both divisor bytes are loaded. With bit 1 = 0, the count wraps at 256, only the low byte (address 1) is loaded, the high byte register (address 2) keeps its value, and `divisor[15:8]` reads 0.
- R6: Control bit 3 = 1 selects synchronous mode. In this mode a write cannot arm the detector (bit 0 reads 0), and line activity leaves the divisor unchanged.
- R7: `rxSuppress` equals the arm bit. It is high from arming until completion, so the receiver discards the measured character.
- R8: Addresses 1 and 2 hold the divisor low and high bytes and can be written and read. Address 0 reads {2'b0, busy, overflow, sync, fast, wide, arm}. A hardware load takes priority over a software write to the same byte in the same cycle.
- R9: After reset, all registers read 0, `divisor` is 0 and `rxSuppress` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous reset, active low |
| rxIn | input | 1 | Asynchronous receive line, idle high |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register write address |
| wrData | input | 8 | Register write data |
| rdAddr | input | 2 | Register read address |
| rdData | output | 8 | Register read data (combinational) |
| divisor | output | 16 | Effective divisor for the baud-rate generator |
| measDone | output | 1 | One-cycle pulse when a measurement completes |
| rxSuppress | output | 1 | Receiver must discard the current character |

## Verification
Two events can fall in the same clock edge: the counter rollover that sets the overflow flag, and a software control write with bit 4 clear that tries to clear it. The bench runs a slow character in 8-bit mode and uses its reference model to find the cycle just before the count passes 255. It issues the clearing write so that it lands on the rollover edge. The flag must read 1 afterwards, and it must still be set after the character completes. A reference model that runs on every clock also checks the divisor, the register reads, `measDone` and `rxSuppress` in every cycle.

// File: rtl/abd_pkg.sv
`timescale 1ns/1ps
package abd_pkg;
  typedef struct packed {
    logic clrCnt;
    logic runCnt;
    logic loadDiv;
  } abd_strobe_t;

  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_DIVLO = 2'd1;

  localparam int BIT_ARM  = 0;
  localparam int BIT_WIDE = 1;
  localparam int BIT_FAST = 2;
  localparam int BIT_SYNC = 3;
  localparam int BIT_OVF  = 4;
  localparam int BIT_BUSY = 5;
endpackage

// File: rtl/abd_ctrl.sv
`timescale 1ns/1ps
module abd_ctrl
  import abd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SYNC_EDGES  = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rxIn,
  input  logic                ctrlWr,
  input  logic [BIT_SYNC:0]   ctrlData,
  output abd_strobe_t         strobe,
  output logic                armQ,
  output logic                measuring,
  output logic                wide16,
  output logic                fastOs,
  output logic                syncMode,
  output logic                measDone
);
  localparam int EDGE_W = $clog2(SYNC_EDGES + 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   rxPrev;
  logic [EDGE_W-1:0]      edgeCnt;
  logic                   fallEdge, wrArm, startEv, doneEv;

  // line synchronizer and falling-edge detector
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ  <= '1;
      rxPrev <= 1'b1;
    end else begin
      syncQ  <= {syncQ[SYNC_STAGES-2:0], rxIn};
      rxPrev <= syncQ[SYNC_STAGES-1];
    end
  end

  assign fallEdge = rxPrev & ~syncQ[SYNC_STAGES-1];
  assign wrArm    = ctrlData[BIT_ARM] & ~ctrlData[BIT_SYNC];
  assign startEv  = armQ & ~measuring & fallEdge & ~syncMode;
  assign doneEv   = measuring & fallEdge & (edgeCnt == EDGE_W'(SYNC_EDGES - 1));

  assign strobe.clrCnt  = startEv;
  assign strobe.runCnt  = measuring;
  assign strobe.loadDiv = doneEv;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armQ      <= 1'b0;
      measuring <= 1'b0;
      wide16    <= 1'b0;
      fastOs    <= 1'b0;
      syncMode  <= 1'b0;
      measDone  <= 1'b0;
      edgeCnt   <= '0;
    end else begin
      measDone <= doneEv;
      if (ctrlWr) begin
        wide16   <= ctrlData[BIT_WIDE];
        fastOs   <= ctrlData[BIT_FAST];
        syncMode <= ctrlData[BIT_SYNC];
        armQ     <= wrArm;
      end
      if (doneEv) armQ <= 1'b0;

      if (ctrlWr && !wrArm)  measuring <= 1'b0;
      else if (startEv)      measuring <= 1'b1;
      else if (doneEv)       measuring <= 1'b0;

      if (startEv)                    edgeCnt <= EDGE_W'(1);
      else if (measuring && fallEdge) edgeCnt <= edgeCnt + 1'b1;
    end
  end

  // R3: completion drops the arm bit and raises the done pulse
  p_arm_clr_r3: assert property (@(posedge clk) disable iff (!rstN)
    doneEv |=> (!armQ && measDone));

  // R6: synchronous mode keeps the detector idle
  p_sync_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    syncMode |-> (!armQ && !measuring));

  // R7: a running measurement is always covered by suppression
  p_suppress_r7: assert property (@(posedge clk) disable iff (!rstN)
    measuring |-> armQ);
endmodule

// File: rtl/abd_dp.sv
`timescale 1ns/1ps
module abd_dp
  import abd_pkg::*;
#(
  parameter int DIV_BYTES = 2,
  parameter int FAST_PRE  = 128,
  parameter int SLOW_PRE  = 512
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  abd_strobe_t            strobe,
  input  logic                   wide16,
  input  logic                   fastOs,
  input  logic                   wrEn,
  input  logic [1:0]             wrAddr,
  input  logic [7:0]             wrData,
  output logic                   ovfFlag,
  output logic [8*DIV_BYTES-1:0] divRaw,
  output logic [8*DIV_BYTES-1:0] divisor
);
  localparam int CNT_W = 8 * DIV_BYTES;
  localparam int PRE_W = $clog2(SLOW_PRE);

  logic [PRE_W-1:0] preCnt, preLim;
  logic [CNT_W-1:0] cnt, cntMask;
  logic             tick, roll, ovfClr;

  assign preLim  = fastOs ? PRE_W'(FAST_PRE - 1) : PRE_W'(SLOW_PRE - 1);
  assign cntMask = wide16 ? {CNT_W{1'b1}} : CNT_W'(8'hFF);
  assign tick    = strobe.runCnt && (preCnt == preLim);
  assign roll    = tick && ((cnt & cntMask) == cntMask);
  assign ovfClr  = wrEn && (wrAddr == ADDR_CTRL) && !wrData[BIT_OVF];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt <= '0;
      cnt    <= '0;
    end else if (strobe.clrCnt) begin
      preCnt <= '0;
      cnt    <= '0;
    end else if (strobe.runCnt) begin
      if (tick) begin
        preCnt <= '0;
        cnt    <= (cnt + 1'b1) & cntMask;
      end else begin
        preCnt <= preCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)       ovfFlag <= 1'b0;
    else if (roll)   ovfFlag <= 1'b1;
    else if (ovfClr) ovfFlag <= 1'b0;
  end

  // R4: a set flag survives every cycle without a clearing write
  p_ovf_sticky_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !ovfClr) |=> ovfFlag);

  // R4: rollover beats a same-cycle clear
  p_ovf_setwins_r4: assert property (@(posedge clk) disable iff (!rstN)
    roll |=> ovfFlag);

  for (genvar b = 0; b < DIV_BYTES; b++) begin : g_lane
    logic [7:0] laneQ;
    logic       laneLoad, laneSw;
    assign laneLoad = strobe.loadDiv && ((b == 0) || wide16);
    assign laneSw   = wrEn && (wrAddr == ADDR_DIVLO + 2'(b));

    always_ff @(posedge clk) begin
      if (!rstN)         laneQ <= '0;
      else if (laneLoad) laneQ <= cnt[8*b +: 8];
      else if (laneSw)   laneQ <= wrData;
    end

    assign divRaw[8*b +: 8]  = laneQ;
    assign divisor[8*b +: 8] = ((b == 0) || wide16) ? laneQ : 8'h00;

    if (b > 0) begin : g_hold
      // R5: narrow-mode loads leave the upper bytes alone
      p_hi_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
        (strobe.loadDiv && !wide16 && !laneSw) |=> $stable(laneQ));
    end
  end
endmodule

// File: rtl/uart_autobaud.sv
`timescale 1ns/1ps
module uart_autobaud
  import abd_pkg::*;
#(
  parameter int DIV_BYTES   = 2,
  parameter int FAST_PRE    = 128,
  parameter int SLOW_PRE    = 512,
  parameter int SYNC_STAGES = 2,
  parameter int SYNC_EDGES  = 5
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   rxIn,
  input  logic                   wrEn,
  input  logic [1:0]             wrAddr,
  input  logic [7:0]             wrData,
  input  logic [1:0]             rdAddr,
  output logic [7:0]             rdData,
  output logic [8*DIV_BYTES-1:0] divisor,
  output logic                   measDone,
  output logic                   rxSuppress
);
  localparam int CNT_W = 8 * DIV_BYTES;

  abd_strobe_t      strobe;
  logic             armQ, measuring, wide16, fastOs, syncMode, ovfFlag;
  logic [CNT_W-1:0] divRaw;
  logic             ctrlWr;

  assign ctrlWr = wrEn && (wrAddr == ADDR_CTRL);

  abd_ctrl #(.SYNC_STAGES(SYNC_STAGES), .SYNC_EDGES(SYNC_EDGES)) ctrl_i (
    .clk(clk), .rstN(rstN), .rxIn(rxIn), .ctrlWr(ctrlWr),
    .ctrlData(wrData[BIT_SYNC:0]), .strobe(strobe), .armQ(armQ),
    .measuring(measuring), .wide16(wide16), .fastOs(fastOs),
    .syncMode(syncMode), .measDone(measDone)
  );

  abd_dp #(.DIV_BYTES(DIV_BYTES), .FAST_PRE(FAST_PRE), .SLOW_PRE(SLOW_PRE)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wide16(wide16), .fastOs(fastOs),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .ovfFlag(ovfFlag),
    .divRaw(divRaw), .divisor(divisor)
  );

  assign rxSuppress = armQ;

  always_comb begin
    rdData = 8'h00;
    if (rdAddr == ADDR_CTRL)
      rdData = {2'b00, measuring, ovfFlag, syncMode, fastOs, wide16, armQ};
    for (int b = 0; b < DIV_BYTES; b++)
      if (rdAddr == 2'(b + 1)) rdData = divRaw[8*b +: 8];
  end
endmodule

// File: tb/uart_autobaud_tb_top.sv
`timescale 1ns/1ps
module uart_autobaud_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int FAST_DIV   = 128;
  localparam int SLOW_DIV   = 512;
  localparam int WATCHDOG   = 195000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rxIn = 1'b1;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = 2'd0;
  logic [7:0]  wrData = 8'h00;
  logic [1:0]  rdAddr = 2'd0;
  logic [7:0]  rdData;
  logic [15:0] divisor;
  logic        measDone, rxSuppress;

  int checks = 0, errors = 0, doneCount = 0;
  bit finished = 0;

  uart_autobaud dut_i (
    .clk(clk), .rstN(rstN), .rxIn(rxIn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .divisor(divisor),
    .measDone(measDone), .rxSuppress(rxSuppress)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model, updated at every rising edge
  bit h0 = 1, h1 = 1, h2 = 1;
  bit mArm, mMeas, mWide, mFast, mSync, mOvf, mDoneQ;
  int mEdges, mJ, mLo, mHi;

  always @(posedge clk) begin
    if (!rstN) begin
      h0 = 1; h1 = 1; h2 = 1;
      mArm = 0; mMeas = 0; mWide = 0; mFast = 0; mSync = 0; mOvf = 0; mDoneQ = 0;
      mEdges = 0; mJ = 0; mLo = 0; mHi = 0;
    end else begin
      bit fall, pStart, pDone, roll, wrCtrl, newArm;
      int p, m, cap;
      p = mFast ? FAST_DIV : SLOW_DIV;
      m = mWide ? 65536 : 256;
      fall   = h0 && !h1;
      pStart = mArm && !mMeas && fall && !mSync;
      pDone  = mMeas && fall && (mEdges == 4);
      cap    = (mJ / p) % m;
      roll   = 0;
      if (mMeas) begin
        mJ++;
        if ((mJ % p == 0) && (((mJ / p) % m) == 0)) roll = 1;
      end
      wrCtrl = wrEn && (wrAddr == 2'd0);
      newArm = wrData[0] && !wrData[3];
      if (roll) mOvf = 1;
      else if (wrCtrl && !wrData[4]) mOvf = 0;
      if (pDone) mLo = cap & 255;
      else if (wrEn && wrAddr == 2'd1) mLo = wrData;
      if (pDone && mWide) mHi = (cap >> 8) & 255;
      else if (wrEn && wrAddr == 2'd2) mHi = wrData;
      if (pStart) mEdges = 1;
      else if (mMeas && fall) mEdges++;
      if (wrCtrl && !newArm) mMeas = 0;
      else if (pStart) begin mMeas = 1; mJ = 0; end
      else if (pDone) mMeas = 0;
      if (wrCtrl) begin
        mWide = wrData[1]; mFast = wrData[2]; mSync = wrData[3]; mArm = newArm;
      end
      if (pDone) mArm = 0;
      mDoneQ = pDone;
      h0 = h1; h1 = h2; h2 = rxIn;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chkNear(input string req, input int act, input int exp);
    int d;
    checks++;
    d = act - exp;
    if (d < -1 || d > 1) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (+/-1)", req, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    #(CLK_PERIOD/4);
    if (rstN && !finished) begin
      int expRd, expDiv;
      expDiv = mWide ? (mHi * 256 + mLo) : mLo;
      case (rdAddr)
        2'd0: expRd = {2'b00, mMeas, mOvf, mSync, mFast, mWide, mArm};
        2'd1: expRd = mLo;
        2'd2: expRd = mHi;
        default: expRd = 0;
      endcase
      chk("R2/R5 divisor per cycle", divisor, expDiv);
      chk("R8 read data per cycle", rdData, expRd);
      chk("R3 measDone per cycle", measDone, mDoneQ);
      chk("R7 rxSuppress per cycle", rxSuppress, mArm);
    end
  end

  always @(negedge clk) if (rstN && measDone) doneCount++;

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = 8'h00;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    rdAddr = a;
    #1;
    v = rdData;
    rdAddr = 2'd0;
  endtask

  task automatic sendByte(input logic [7:0] b, input int t);
    rxIn = 1'b0;
    repeat (t) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxIn = b[i];
      repeat (t) @(negedge clk);
    end
    rxIn = 1'b1;
    repeat (t) @(negedge clk);
  endtask

  task automatic finishRun();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d cycles", WATCHDOG, 0);
    finishRun();
  end

  initial begin
    logic [7:0] v;
    int saved;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R9 reset state
    rd(2'd0, v); chk("R9 ctrl reset", v, 0);
    rd(2'd1, v); chk("R9 divlo reset", v, 0);
    chk("R9 divisor reset", divisor, 0);
    chk("R9 rxSuppress reset", rxSuppress, 0);

    // R8 software access to divisor bytes
    wr(2'd1, 8'h34); wr(2'd2, 8'h12); wr(2'd0, 8'h02);
    rd(2'd1, v); chk("R8 divlo readback", v, 8'h34);
    rd(2'd2, v); chk("R8 divhi readback", v, 8'h12);
    chk("R5 wide divisor", divisor, 16'h1234);
    wr(2'd0, 8'h00);
    chk("R5 narrow divisor hides high byte", divisor, 16'h0034);

    // R1/R2/R3/R7 fast 8-bit measurement, T=160
    wr(2'd0, 8'h05);
    rd(2'd0, v); chk("R1 arm bit set", v[0], 1);
    chk("R7 suppress while armed", rxSuppress, 1);
    repeat (20) @(negedge clk);
    sendByte(8'h55, 160);
    repeat (5) @(negedge clk);
    chkNear("R2 fast 8-bit T=160", divisor, (8*160)/FAST_DIV);
    rd(2'd0, v); chk("R3 arm cleared", v[0], 0);
    chk("R3 single done pulse", doneCount, 1);
    chk("R7 suppress released", rxSuppress, 0);
    saved = divisor;

    // R1 unarmed character ignored
    sendByte(8'h55, 320);
    repeat (5) @(negedge clk);
    chk("R1 second character ignored", divisor, saved);

    // R6 synchronous mode
    wr(2'd0, 8'h0D);
    rd(2'd0, v); chk("R6 arm refused in sync mode", v[0], 0);
    sendByte(8'h55, 320);
    repeat (5) @(negedge clk);
    chk("R6 divisor untouched in sync mode", divisor, saved);
    wr(2'd0, 8'h00);

    // R2/R5 slow 16-bit, T=1024
    wr(2'd0, 8'h03);
    sendByte(8'h55, 1024);
    repeat (5) @(negedge clk);
    chkNear("R2 slow 16-bit T=1024", divisor, (8*1024)/SLOW_DIV);

    // R5 16-bit count past 255, T=4100
    wr(2'd0, 8'h07);
    sendByte(8'h55, 4100);
    repeat (5) @(negedge clk);
    chkNear("R5 wide count T=4100", divisor, (8*4100)/FAST_DIV);
    rd(2'd2, v); chk("R5 high byte loaded", v, 1);
    rd(2'd0, v); chk("R4 no overflow in wide mode", v[4], 0);

    // R4/R5 narrow wrap with a clearing write on the rollover edge
    wr(2'd2, 8'hAB);
    wr(2'd0, 8'h05);
    fork
      sendByte(8'h55, 4200);
      begin
        do @(negedge clk); while (!(mMeas && mJ == 256*FAST_DIV - 1));
        wr(2'd0, 8'h05);
        rd(2'd0, v); chk("R4 rollover beats clear", v[4], 1);
      end
    join
    repeat (5) @(negedge clk);
    chkNear("R5 narrow wrap T=4200", divisor, ((8*4200)/FAST_DIV) % 256);
    rd(2'd2, v); chk("R5 high register kept", v, 8'hAB);
    chk("R5 divisor high byte zero", divisor[15:8], 0);
    rd(2'd0, v); chk("R4 overflow sticky", v[4], 1);
    wr(2'd0, 8'h10);
    rd(2'd0, v); chk("R4 write of one keeps flag", v[4], 1);
    wr(2'd0, 8'h00);
    rd(2'd0, v); chk("R4 write of zero clears flag", v[4], 0);

    repeat (3) @(negedge clk);
    finishRun();
  end
endmodule